// File: doc/BRIEF.md
# Clock-Selection Watchdog with Recovery

This block guards the frequency-selection word of a clock synthesizer. Software programs a timeout code, a restore-mode bit, an override bit and a software selection word through a small register write port. A hardware strap word is captured while reset is held. Once armed, a countdown advances on a 1 kHz enable tick. If software fails to reload it in time, the block raises a sticky alarm and forces the active selection to a recovery source. That source is either the strapped word or the last software word, chosen by the restore-mode bit.

Outside an alarm, the active selection follows the software word when the override bit is set, and the strapped word otherwise. The alarm clears only when software writes a zero timeout code. The active selection and the alarm are registered and change on the same clock edge.

Top module: `wdt_freq_recover`

## Requirements
- R1: In reset, alarm_o is 0 and active_sel_o equals strap_sel_i. The strap is sampled only while rst is high, and later changes on strap_sel_i have no effect.
- R2: Timeout code 0 disables the watchdog: no number of ticks sets the alarm.
- R3: Code 1 arms a 10-tick period. alarm_o rises on the clock edge that samples the 10th tick after the write, and not before. Cycles with tick_i low do not count.
- R4: Codes 2 to 15 arm a period of code×2000 ticks (code×2 seconds at one tick per millisecond).
- R5: Any write of a nonzero code to the control register reloads the full period, even while counting. If the write falls in the same cycle as the final tick, the write wins and no alarm is raised.
- R6: The alarm is sticky. Only a control write with code 0 clears it, and a nonzero rewrite leaves it set. A zero-code write in the same cycle as the final tick leaves the alarm at 0.
- R7: After expiry the counter stays idle until a nonzero code is written again, which re-arms it.
- R8: With no alarm, active_sel_o equals the software word when override is 1, and the strapped word when override is 0.
- R9: With the alarm set, active_sel_o equals the software word if restore-mode is 1, and the strapped word if it is 0, whatever the override bit.
- R10: Register map: address 0 is control, with bits [3:0] = timeout code, bit 4 = restore-mode and bit 5 = override. Address 1 holds the software selection word. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap captured while high |
| strap_sel_i | input | SEL_W | Hardware strap selection word |
| tick_i | input | 1 | One-cycle millisecond enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | SEL_W | Register write data |
| active_sel_o | output | SEL_W | Active frequency selection |
| alarm_o | output | 1 | Watchdog expired flag |

## Verification
A control write and the final countdown tick can land in the same cycle. A nonzero-code write then has to win as a keep-alive, and a zero-code write has to leave the alarm clear. The bench arms code 1 and counts nine ticks. It then asserts tick together with each kind of write, and checks after that edge that alarm_o is still 0 and that the selection matches the non-alarm rule. Random traffic with short codes repeats such collisions, and a bench model judges every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 2;
  localparam int CODE_W = 4;
  localparam int NCODES = 1 << CODE_W;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 2'd0,
    ADR_SEL  = 2'd1
  } wdt_addr_e;

  typedef struct packed {
    logic              ovr;
    logic              mode;
    logic [CODE_W-1:0] code;
  } wdt_ctrl_t;

  localparam int CTRL_W = $bits(wdt_ctrl_t);
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  strap_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SEL_W-1:0]  wr_data_i,
  output wdt_ctrl_t         ctrl_d,
  output wdt_ctrl_t         ctrl_q,
  output logic [SEL_W-1:0]  sw_d,
  output logic [SEL_W-1:0]  sw_q,
  output logic [SEL_W-1:0]  hw_q,
  output logic              ctrl_wr
);
  logic sel_wr;

  always_comb begin
    ctrl_wr = wr_en_i && (wr_addr_i == ADR_CTRL);
    sel_wr  = wr_en_i && (wr_addr_i == ADR_SEL);
    ctrl_d  = ctrl_q;
    sw_d    = sw_q;
    if (ctrl_wr) ctrl_d = wdt_ctrl_t'(wr_data_i[CTRL_W-1:0]);
    if (sel_wr)  sw_d   = wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      sw_q   <= '0;
      hw_q   <= strap_i;
    end else begin
      ctrl_q <= ctrl_d;
      sw_q   <= sw_d;
    end
  end

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(hw_q)) else $error("strap changed"); // R1

  AST_ODD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i[1]) |=> ($stable(ctrl_q) && $stable(sw_q)))
    else $error("write to unused address took effect"); // R10
endmodule

// File: rtl/wdt_decode.sv
module wdt_decode
  import wdt_pkg::*;
#(
  parameter int SEC_TICKS   = 1000,
  parameter int SHORT_TICKS = 10,
  parameter int CNT_W       = 15
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  load_o
);
  logic [CNT_W-1:0] tbl [NCODES];

  for (genvar k = 0; k < NCODES; k++) begin : g_tbl
    if (k == 0) begin : g_off
      assign tbl[k] = '0;
    end else if (k == 1) begin : g_short
      assign tbl[k] = CNT_W'(SHORT_TICKS);
    end else begin : g_sec
      assign tbl[k] = CNT_W'(k * 2 * SEC_TICKS);
    end
  end

  assign load_o = tbl[code_i];
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  load_i,
  input  logic              tick_i,
  output logic              alarm_d,
  output logic              alarm_q
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             armed_d, armed_q;
  logic             last_tick;

  always_comb begin
    cnt_d     = cnt_q;
    armed_d   = armed_q;
    alarm_d   = alarm_q;
    last_tick = armed_q && tick_i && (cnt_q == CNT_W'(1));
    if (ctrl_wr_i) begin
      if (code_i == '0) begin
        cnt_d   = '0;
        armed_d = 1'b0;
        alarm_d = 1'b0;
      end else begin
        cnt_d   = load_i;
        armed_d = 1'b1;
      end
    end else if (armed_q && tick_i) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (last_tick) begin
        armed_d = 1'b0;
        alarm_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      alarm_q <= alarm_d;
    end
  end

  AST_ALARM_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_q) |-> $past(armed_q && tick_i && !ctrl_wr_i))
    else $error("alarm rose without expiry"); // R3

  AST_ALARM_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_q) |-> $past(ctrl_wr_i && (code_i == '0)))
    else $error("alarm cleared without zero code"); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !ctrl_wr_i) |=> ($stable(cnt_q) && !armed_q))
    else $error("idle counter moved"); // R7

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr_i && (code_i != '0)) |=> (armed_q && cnt_q == $past(load_i)))
    else $error("keep-alive did not reload"); // R5

  AST_OFF_NO_ALARM: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr_i && (code_i == '0)) |=> (!alarm_q && !armed_q))
    else $error("zero code left watchdog running"); // R2
endmodule

// File: rtl/wdt_selmux.sv
module wdt_selmux #(
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             alarm_d_i,
  input  logic             mode_d_i,
  input  logic             ovr_d_i,
  input  logic [SEL_W-1:0] sw_d_i,
  input  logic [SEL_W-1:0] hw_i,
  output logic [SEL_W-1:0] sel_o
);
  logic use_sw;

  always_comb begin
    if (alarm_d_i) use_sw = mode_d_i;
    else           use_sw = ovr_d_i;
  end

  always_ff @(posedge clk) begin
    if (rst) sel_o <= strap_i;
    else     sel_o <= use_sw ? sw_d_i : hw_i;
  end
endmodule

// File: rtl/wdt_freq_recover.sv
module wdt_freq_recover
  import wdt_pkg::*;
#(
  parameter int SEL_W       = 8,
  parameter int SEC_TICKS   = 1000,
  parameter int SHORT_TICKS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  strap_sel_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SEL_W-1:0]  wr_data_i,
  output logic [SEL_W-1:0]  active_sel_o,
  output logic              alarm_o
);
  localparam int MAX_TICKS = (NCODES - 1) * 2 * SEC_TICKS;
  localparam int TOP_TICKS = (MAX_TICKS > SHORT_TICKS) ? MAX_TICKS : SHORT_TICKS;
  localparam int CNT_W     = $clog2(TOP_TICKS + 1);

  wdt_ctrl_t        ctrl_d, ctrl_q;
  logic [SEL_W-1:0] sw_d, sw_q, hw_q;
  logic             ctrl_wr;
  logic [CNT_W-1:0] load_val;
  logic             alarm_d;

  wdt_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .strap_i(strap_sel_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ctrl_d(ctrl_d), .ctrl_q(ctrl_q), .sw_d(sw_d), .sw_q(sw_q),
    .hw_q(hw_q), .ctrl_wr(ctrl_wr)
  );

  wdt_decode #(.SEC_TICKS(SEC_TICKS), .SHORT_TICKS(SHORT_TICKS), .CNT_W(CNT_W)) u_dec (
    .code_i(ctrl_d.code), .load_o(load_val)
  );

  wdt_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr), .code_i(ctrl_d.code),
    .load_i(load_val), .tick_i(tick_i), .alarm_d(alarm_d), .alarm_q(alarm_o)
  );

  wdt_selmux #(.SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst(rst), .strap_i(strap_sel_i), .alarm_d_i(alarm_d),
    .mode_d_i(ctrl_d.mode), .ovr_d_i(ctrl_d.ovr), .sw_d_i(sw_d),
    .hw_i(hw_q), .sel_o(active_sel_o)
  );

  AST_RECOVER_HW: assert property (@(posedge clk) disable iff (rst)
    (alarm_o && !ctrl_q.mode) |-> (active_sel_o == hw_q))
    else $error("alarm did not restore strap"); // R9

  AST_RECOVER_SW: assert property (@(posedge clk) disable iff (rst)
    (alarm_o && ctrl_q.mode) |-> (active_sel_o == sw_q))
    else $error("alarm did not restore software word"); // R9

  AST_NORMAL_SEL: assert property (@(posedge clk) disable iff (rst)
    !alarm_o |-> (active_sel_o == (ctrl_q.ovr ? sw_q : hw_q)))
    else $error("normal selection wrong"); // R8
endmodule

// File: tb/wdt_freq_recover_bench.sv
module wdt_freq_recover_bench;
  localparam int SEL_W = 8;
  localparam int SEC_TICKS = 1000;

  logic             clk = 1'b0;
  logic             rst;
  logic [SEL_W-1:0] strap;
  logic             tick, we;
  logic [1:0]       addr;
  logic [SEL_W-1:0] wdata;
  logic [SEL_W-1:0] act_sel;
  logic             alarm;

  int n_tests = 0;
  int n_fail  = 0;

  // model state
  logic [3:0]       m_code;
  logic             m_mode, m_ovr, m_alarm, m_armed;
  logic [SEL_W-1:0] m_sw, m_hw;
  int               m_cnt;

  always #2 clk = ~clk;

  wdt_freq_recover #(.SEL_W(SEL_W), .SEC_TICKS(SEC_TICKS), .SHORT_TICKS(10)) u_wdt_freq_recover (
    .clk(clk), .rst(rst), .strap_sel_i(strap), .tick_i(tick), .wr_en_i(we),
    .wr_addr_i(addr), .wr_data_i(wdata), .active_sel_o(act_sel), .alarm_o(alarm)
  );

  function automatic int period(input logic [3:0] c);
    if (c == 4'd0) return 0;
    if (c == 4'd1) return 10;
    return int'(c) * 2 * SEC_TICKS;
  endfunction

  function automatic logic [SEL_W-1:0] exp_sel();
    if (m_alarm) return m_mode ? m_sw : m_hw;
    return m_ovr ? m_sw : m_hw;
  endfunction

  task automatic model_edge(input logic w, input logic [1:0] a, input logic [SEL_W-1:0] d, input logic t);
    if (w && a == 2'd1) m_sw = d;
    if (w && a == 2'd0) begin
      m_code = d[3:0]; m_mode = d[4]; m_ovr = d[5];
      if (d[3:0] == 4'd0) begin m_alarm = 1'b0; m_armed = 1'b0; m_cnt = 0; end
      else begin m_armed = 1'b1; m_cnt = period(d[3:0]); end
    end else if (m_armed && t) begin
      m_cnt--;
      if (m_cnt == 0) begin m_armed = 1'b0; m_alarm = 1'b1; end
    end
  endtask

  task automatic check(input string tag);
    n_tests++;
    if (alarm !== m_alarm) begin
      n_fail++;
      $display("FAIL %s alarm act=%0b exp=%0b", tag, alarm, m_alarm);
    end
    n_tests++;
    if (act_sel !== exp_sel()) begin
      n_fail++;
      $display("FAIL %s sel act=%0h exp=%0h", tag, act_sel, exp_sel());
    end
  endtask

  // called at a negedge; leaves at the following negedge after checking
  task automatic step(input logic w, input logic [1:0] a, input logic [SEL_W-1:0] d,
                      input logic t, input string tag);
    we = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    model_edge(w, a, d, t);
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    check(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, 1'b1, tag);
  endtask

  task automatic wr_ctrl(input logic ovr, input logic mode, input logic [3:0] code, input string tag);
    step(1'b1, 2'd0, SEL_W'({ovr, mode, code}), 1'b0, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, run hung (all requirements)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; strap = 8'hA5; tick = 0; we = 0; addr = 0; wdata = 0;
    m_code = 0; m_mode = 0; m_ovr = 0; m_alarm = 0; m_armed = 0; m_cnt = 0;
    m_sw = 0; m_hw = 8'hA5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset");
    strap = 8'h3C;
    ticks(3, "R1 strap ignored after reset");

    // R2: code 0, ticks do nothing
    wr_ctrl(1'b0, 1'b0, 4'd0, "R2");
    ticks(40, "R2 disabled");

    // R10 software word and unused addresses
    step(1'b1, 2'd1, 8'h5B, 1'b0, "R10 sw write");
    wr_ctrl(1'b1, 1'b0, 4'd0, "R8 override on");
    step(1'b1, 2'd2, 8'h3F, 1'b0, "R10 addr2 ignored");
    step(1'b1, 2'd3, 8'hFF, 1'b0, "R10 addr3 ignored");

    // R3: code 1, gaps without tick, expiry at 10th tick
    wr_ctrl(1'b1, 1'b0, 4'd1, "R3 arm");
    for (int i = 0; i < 9; i++) begin
      step(1'b0, 2'd0, '0, 1'b1, "R3 counting");
      step(1'b0, 2'd0, '0, 1'b0, "R3 no tick");
    end
    step(1'b0, 2'd0, '0, 1'b1, "R3 expiry R9 restore hw");
    ticks(5, "R7 idle after expiry");
    wr_ctrl(1'b1, 1'b1, 4'd1, "R6 nonzero keeps alarm R9 sw");
    ticks(10, "R7 re-armed");
    wr_ctrl(1'b1, 1'b0, 4'd0, "R6 clear");

    // R5: keep-alive on final tick
    wr_ctrl(1'b1, 1'b0, 4'd1, "R5 arm");
    ticks(9, "R5 count");
    step(1'b1, 2'd0, 8'h21, 1'b1, "R5 reload beats last tick");
    ticks(9, "R5 after reload");
    step(1'b1, 2'd0, 8'h20, 1'b1, "R6 zero write beats last tick");
    ticks(12, "R2 stays off");

    // R4: longest and a middle code
    wr_ctrl(1'b0, 1'b1, 4'd15, "R4 code15");
    ticks(30000 - 1, "R4 code15 count");
    ticks(1, "R4 code15 expiry");
    wr_ctrl(1'b0, 1'b0, 4'd0, "R6 clear");
    wr_ctrl(1'b1, 1'b0, 4'd3, "R4 code3");
    ticks(6000, "R4 code3 expiry");
    wr_ctrl(1'b0, 1'b0, 4'd0, "R6 clear");

    // random traffic
    for (int i = 0; i < 30000; i++) begin
      logic w, t;
      logic [1:0] a;
      logic [SEL_W-1:0] d;
      int r;
      w = ($urandom % 30) == 0;
      t = ($urandom % 2) == 0;
      a = 2'($urandom % 4);
      d = 8'($urandom);
      if (w && a == 2'd0) begin
        r = $urandom % 10;
        d[3:0] = (r < 2) ? 4'd0 : (r < 9) ? 4'd1 : 4'd2;
      end
      step(w, a, d, t, "R5 R6 R8 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule